// File: doc/BRIEF.md
# General-purpose I/O controller with change interrupts

This block gives software control over up to 32 general-purpose lines through a small 32-bit register bus. Each line can be an input or an output. One data register drives the output values and reads back the line levels. Input levels pass through a two-flop synchronizer. Any rising or falling transition on a synchronized line sets a sticky change bit. Software clears a change bit by writing 1 to it. A per-line enable register selects which change bits drive the one combined interrupt output.

A bus access is a single cycle with `bus_req` high. A write takes effect at that clock edge. `bus_ready` pulses on the next cycle, and on a read `bus_rdata` is valid in that same cycle. The parameter `NLINES` sets how many lines are implemented. The word registers sit at byte offsets 0x00 (direction), 0x04 (data), 0x08 (interrupt enable), 0x0C (change status), 0x10 (data write mask) and 0x14 (trigger type).

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every line is an input (`pin_oe` = 0). `pin_out`, the change register and the enable register are 0. The write mask reads all ones for the implemented lines, and `irq` is low.
- R2: Every cycle with `bus_req` high is answered by `bus_ready` high on the next cycle, with read data valid in that cycle. `bus_ready` is low on the cycle after a cycle without a request.
- R3: In the direction register (offset 0x00), a bit at 1 makes that line an output, and `pin_oe` shows this register. `pin_oe` changes only after a write to offset 0x00.
- R4: A read of the data register (offset 0x04) returns the output value for lines set as outputs. For lines set as inputs it returns the synchronized pin level. A new pin level is visible to a read issued three cycles after the change.
- R5: A write to the data register (offset 0x04) updates only the output bits whose write-mask bit (offset 0x10) is 1. `pin_out` changes only after such a write.
- R6: A rising or a falling transition on an input pin sets that line's change bit (offset 0x0C), which is readable three cycles after the pin changes.
- R7: Writing 1 to a change bit clears it. Writing 0 leaves it unchanged, and a change bit is never cleared any other way.
- R8: `irq` is high exactly when some line has both its change bit and its enable bit (offset 0x08) set.
- R9: When a transition is detected in the same cycle as a write-1 clear of the same change bit, the bit stays set.
- R10: The trigger type register (offset 0x14) reads all ones for the implemented lines and ignores writes.
- R11: Bits at or above `NLINES` read 0 and ignore writes. Offsets 0x18 and above, and any byte address that is not word aligned, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access completed |
| pin_in | input | NLINES | Pin levels from the pads |
| pin_out | output | NLINES | Output values to the pads |
| pin_oe | output | NLINES | Output enables, 1 = drive |
| irq | output | 1 | Combined change interrupt |

## Verification
A lost or spurious change bit shows on `irq` in the cycle after the fault for an enabled line. For a masked line it shows only when software reads the change register back. A stale synchronizer stage shows in a data read issued three cycles after a pin change, and as a change bit that is missing or late. Corrupt direction or output state reaches `pin_oe` and `pin_out` directly, while a wrong write mask shows only on the next data write. The bench therefore reads back after every write, and it reads with exact cycle spacing around the clear-versus-edge collision.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NLINES = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_DIR  = WW'(0);
  localparam logic [WW-1:0] W_DATA = WW'(1);
  localparam logic [WW-1:0] W_IEN  = WW'(2);
  localparam logic [WW-1:0] W_CHG  = WW'(3);
  localparam logic [WW-1:0] W_MASK = WW'(4);
  localparam logic [WW-1:0] W_TYPE = WW'(5);

  logic [NLINES-1:0] dir_q, out_q, ien_q, chg_q, wmask_q;
  logic [NLINES-1:0] sync1, sync2, prev;
  logic [NLINES-1:0] edge_hit, wd, clr_bits, data_view;
  logic [WW-1:0]     word;
  logic              hit, wr;
  logic [31:0]       rd_val;
  logic              unused_wdata;

  assign word         = bus_addr[ADDR_W-1:2];
  assign hit          = bus_req && (bus_addr[1:0] == 2'b00);
  assign wr           = hit && bus_we;
  assign wd           = bus_wdata[NLINES-1:0];
  assign unused_wdata = ^bus_wdata;
  assign edge_hit     = sync2 ^ prev;
  assign clr_bits     = (wr && word == W_CHG) ? wd : '0;
  assign data_view    = (dir_q & out_q) | (~dir_q & sync2);

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(chg_q & ien_q);

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (word)
        W_DIR:   rd_val[NLINES-1:0] = dir_q;
        W_DATA:  rd_val[NLINES-1:0] = data_view;
        W_IEN:   rd_val[NLINES-1:0] = ien_q;
        W_CHG:   rd_val[NLINES-1:0] = chg_q;
        W_MASK:  rd_val[NLINES-1:0] = wmask_q;
        W_TYPE:  rd_val[NLINES-1:0] = '1;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      prev      <= '0;
      chg_q     <= '0;
      dir_q     <= '0;
      out_q     <= '0;
      ien_q     <= '0;
      wmask_q   <= '1;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      sync1     <= pin_in;
      sync2     <= sync1;
      prev      <= sync2;
      chg_q     <= (chg_q & ~clr_bits) | edge_hit;
      bus_ready <= bus_req;
      if (bus_req && !bus_we) bus_rdata <= rd_val;
      if (wr && word == W_DIR)  dir_q   <= wd;
      if (wr && word == W_DATA) out_q   <= (out_q & ~wmask_q) | (wd & wmask_q);
      if (wr && word == W_IEN)  ien_q   <= wd;
      if (wr && word == W_MASK) wmask_q <= wd;
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NLINES = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_ready,
  input logic [NLINES-1:0] pin_out,
  input logic [NLINES-1:0] pin_oe,
  input logic              irq,
  input logic [NLINES-1:0] chg,
  input logic [NLINES-1:0] edge_hit
);
  // R2
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && bus_addr == ADDR_W'(0)) |=> $stable(pin_oe));
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && bus_addr == ADDR_W'(4)) |=> $stable(pin_out));
  // R7
  chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && bus_addr == ADDR_W'(12)) |=> ((chg & $past(chg)) == $past(chg)));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|edge_hit) || $past(bus_req && bus_we && bus_addr == ADDR_W'(8))));

  if (NLINES < 32) begin : g_hi
    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> (bus_rdata[31:NLINES] == '0));
  end
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .chg(chg_q), .edge_hit(edge_hit)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  localparam int NL = 24;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_ready;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic          irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl #(.NLINES(NL), .ADDR_W(AW)) u_gpio_edge_ctrl (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_ready, .pin_in, .pin_out, .pin_oe, .irq);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    chk(bus_ready == 1'b1, "R2 ready after request", {31'b0, bus_ready}, 32'h1);
    bus_req = 1'b0;
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_read(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset;
    chk(pin_oe == '0, "R1 pin_oe", 32'(pin_oe), 32'h0);
    chk(pin_out == '0, "R1 pin_out", 32'(pin_out), 32'h0);
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    chk(bus_ready == 1'b0, "R2 idle ready", {31'b0, bus_ready}, 32'h0);
    expect_reg(5'h00, 32'h0, "R1 direction");
    expect_reg(5'h08, 32'h0, "R1 enable");
    expect_reg(5'h0C, 32'h0, "R1 change");
    expect_reg(5'h10, 32'h00FF_FFFF, "R1 write mask");
    @(negedge clk);
    chk(bus_ready == 1'b0, "R2 ready drops", {31'b0, bus_ready}, 32'h0);
  endtask

  task automatic t_outputs;
    bus_write(5'h00, 32'h0000_F0F0);
    chk(pin_oe == 24'h00F0F0, "R3 pin_oe", 32'(pin_oe), 32'h0000_F0F0);
    bus_write(5'h04, 32'h0000_A5A5);
    chk(pin_out == 24'h00A5A5, "R5 pin_out full mask", 32'(pin_out), 32'h0000_A5A5);
    expect_reg(5'h04, 32'h0000_A0A0, "R4 data read of outputs");
  endtask

  task automatic t_inputs;
    pin_in = 24'h0F0F0F;
    repeat (3) @(negedge clk);
    expect_reg(5'h04, 32'h000F_AFAF, "R4 data read mixed");
    expect_reg(5'h0C, 32'h000F_0F0F, "R6 rising edges");
    chk(irq == 1'b0, "R8 masked irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    bus_write(5'h10, 32'h0000_00FF);
    bus_write(5'h04, 32'h00FF_FFFF);
    chk(pin_out == 24'h00A5FF, "R5 masked write", 32'(pin_out), 32'h0000_A5FF);
    bus_write(5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    bus_write(5'h08, 32'h0000_0001);
    chk(irq == 1'b1, "R8 enabled change", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h0010_0000);
    chk(irq == 1'b0, "R8 enable without change", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear;
    bus_write(5'h0C, 32'h0);
    expect_reg(5'h0C, 32'h000F_0F0F, "R7 write zero keeps");
    bus_write(5'h0C, 32'h0000_000F);
    expect_reg(5'h0C, 32'h000F_0F00, "R7 partial clear");
    bus_write(5'h0C, 32'hFFFF_FFFF);
    expect_reg(5'h0C, 32'h0, "R7 full clear");
  endtask

  task automatic t_falling;
    bus_write(5'h08, 32'h0000_0001);
    pin_in = 24'h0F0F0E;
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8 irq on falling edge", {31'b0, irq}, 32'h1);
    expect_reg(5'h0C, 32'h0000_0001, "R6 falling edge");
  endtask

  task automatic t_race;
    pin_in = 24'h0F0F0C;
    repeat (3) @(negedge clk);
    expect_reg(5'h0C, 32'h0000_0003, "R6 second line");
    pin_in = 24'h0F0F0E;
    @(negedge clk);
    bus_write(5'h0C, 32'h0000_0003);
    expect_reg(5'h0C, 32'h0000_0002, "R9 edge beats clear");
  endtask

  task automatic t_type;
    expect_reg(5'h14, 32'h00FF_FFFF, "R10 type reads ones");
    bus_write(5'h14, 32'h0);
    expect_reg(5'h14, 32'h00FF_FFFF, "R10 type ignores write");
  endtask

  task automatic t_upper;
    bus_write(5'h00, 32'hFFFF_FFFF);
    expect_reg(5'h00, 32'h00FF_FFFF, "R11 upper bits dropped");
    chk(pin_oe == 24'hFFFFFF, "R3 all outputs", 32'(pin_oe), 32'h00FF_FFFF);
    expect_reg(5'h18, 32'h0, "R11 unmapped offset");
    expect_reg(5'h05, 32'h0, "R11 misaligned address");
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_inputs();
    t_mask();
    t_irq();
    t_clear();
    t_falling();
    t_race();
    t_type();
    t_upper();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule